// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Noise Flag and Receiver Sleep

This block sends and receives asynchronous NRZ frames: a low start bit, 8 or 9 data bits sent least significant bit first, an optional parity bit and one high stop bit. Between frames the line rests high. A modulus divider turns the system clock into a sample tick, and one bit lasts sixteen ticks. The transmitter keeps one holding register in front of its shift register. The receiver keeps one holding register behind its shifter.

The receiver confirms a start edge on three early samples of the start bit. It decides each later bit by a two-of-three vote in the middle of the bit. When the three votes disagree, the frame is marked noisy. The receiver also reports framing, parity and overrun errors. Software can put the receiver to sleep. While asleep, the receiver discards frames until it sees one of two things, depending on the chosen method: a stretch of idle line, or a frame whose top data bit is set.

Top module: `aser_top`

## Requirements
- R1: After reset `txd` is 1, `tx_hold_empty` is 1, and `rx_full`, `rx_noise`, `rx_frame_err`, `rx_par_err`, `rx_overrun` and `rx_asleep` are 0.
- R2: A frame is one 0 start bit, then the data bits LSB first (8 bits, or 9 when `nine_bit`=1), then a parity bit if `par_en`=1, then one 1 stop bit. Each bit lasts 16 ticks, and one tick is `baud_div` clocks. A frame sent on `txd` and looped back to `rxd` is received with the same data.
- R3: The parity bit makes the count of ones across the data bits and the parity bit even when `par_odd`=0 and odd when `par_odd`=1. The receiver sets `rx_par_err` when a received frame breaks this rule.
- R4: Each data, parity and stop bit takes the majority of samples 7, 8 and 9 of the bit. If those three samples disagree in any bit of a frame, `rx_noise` is set and the data still holds the majority values.
- R5: A start bit is accepted only if samples 3, 5 and 7 all read 0. A low pulse shorter than this is dropped and never sets `rx_full`.
- R6: A stop bit voted 0 sets `rx_frame_err` for that frame.
- R7: A frame that completes while `rx_full`=1 sets `rx_overrun`. Its data is discarded and `rx_data` keeps the earlier frame.
- R8: `tx_wr` loads the holding register only while `tx_hold_empty`=1. A write while the holding register is full is ignored. The holding register moves to the shifter once the shifter is idle, which frees room for a second write during a frame.
- R9: While `tx_en`=0 no new frame starts and `txd` stays 1. While `rx_en`=0 the receiver ignores the line.
- R10: A pulse on `sleep_req` sets `rx_asleep`. With `wake_addr`=0, frames are not delivered while asleep. The receiver wakes after 160 consecutive idle-line ticks (176 when `nine_bit`=1).
- R11: With `wake_addr`=1, a frame whose top data bit (bit 7, or bit 8 in 9-bit mode) is 0 is discarded while asleep. A frame whose top data bit is 1 clears `rx_asleep` and is delivered. The idle line does not wake the receiver in this mode.
- R12: A pulse on `rx_rd` clears `rx_full` and all four error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | 13 | Clocks per sample tick (0 stops the tick) |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en | input | 1 | Adds a parity bit to each frame |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| wake_addr | input | 1 | Wake method: 1 for address bit, 0 for idle line |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| tx_wr | input | 1 | Writes `tx_data` into the transmit holding register |
| tx_data | input | 9 | Transmit word |
| tx_hold_empty | output | 1 | Transmit holding register can take a write |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_rd | input | 1 | Pulse that takes the received word and clears the flags |
| rx_data | output | 9 | Received word |
| rx_full | output | 1 | Receive holding register holds a word |
| rx_noise | output | 1 | Samples disagreed inside the frame |
| rx_frame_err | output | 1 | Stop bit read low |
| rx_par_err | output | 1 | Parity mismatch |
| rx_overrun | output | 1 | A frame was lost because the holding register was full |
| rx_asleep | output | 1 | Receiver is in wake-up sleep |

## Verification
The main path runs in loopback over every combination of word length, parity enable and parity sense. Each combination sends all-zero, all-ones and alternating words, which separates bit-order and bit-count faults from parity-sense faults. Frames driven by the bench add single-sample glitches, a wrong parity bit, a low stop bit and short low pulses. These tell the vote, the noise flag, the framing check and the start confirmation apart from the plain data path. The wake-up methods are tried with the line left idle just short of and just past the required number of ticks, and with address frames whose top bit is 0 and 1.

// File: rtl/aser_pkg.sv
package aser_pkg;
  localparam int SAMPLES = 16;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;
endpackage

// File: rtl/aser_baud.sv
module aser_baud #(
  parameter int DIVW = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (div != '0) && (cnt_q >= div - DIVW'(1));
    cnt_d = (div == '0 || tick) ? '0 : cnt_q + DIVW'(1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  // ticks are spaced by the divisor, never back to back when it exceeds one
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > DIVW'(1)) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/aser_tx.sv
module aser_tx #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          nine,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          hold_empty,
  output logic          txd
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(FW + 1);

  logic [DW-1:0] hold_q, hold_d;
  logic          full_q, full_d;
  logic [FW-1:0] sh_q, sh_d, fr;
  logic [CW-1:0] left_q, left_d, nd;
  logic [3:0]    sub_q, sub_d;
  logic          busy_q, busy_d, line_q, line_d, load, pbit;
  logic [DW-1:0] dm;

  always_comb begin
    hold_d = hold_q; full_d = full_q; sh_d = sh_q; left_d = left_q;
    sub_d = sub_q; busy_d = busy_q; line_d = line_q;
    nd   = nine ? CW'(DW) : CW'(DW - 1);
    dm   = nine ? hold_q : {1'b0, hold_q[DW-2:0]};
    pbit = (^dm) ^ par_odd;
    fr   = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (CW'(i) < nd) fr[i+1] = dm[i];
    if (par_en) fr[nd + CW'(1)] = pbit;
    load = tick && tx_en && !busy_q && full_q;
    if (wr && !full_q) begin
      hold_d = wdata;
      full_d = 1'b1;
    end
    if (load) begin
      full_d = 1'b0;
      sh_d   = fr;
      left_d = nd + CW'(2) + CW'(par_en);
      sub_d  = '0;
      busy_d = 1'b1;
      line_d = 1'b0;
    end else if (busy_q && tick) begin
      sub_d = sub_q + 4'd1;
      if (sub_q == 4'd15) begin
        if (left_q == CW'(1)) begin
          busy_d = 1'b0;
          line_d = 1'b1;
        end else begin
          sh_d   = {1'b1, sh_q[FW-1:1]};
          line_d = sh_q[1];
          left_d = left_q - CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_q <= '0; full_q <= 1'b0; sh_q <= '1; left_q <= '0;
      sub_q <= '0; busy_q <= 1'b0; line_q <= 1'b1;
    end else begin
      hold_q <= hold_d; full_q <= full_d; sh_q <= sh_d; left_q <= left_d;
      sub_q <= sub_d; busy_q <= busy_d; line_q <= line_d;
    end

  assign hold_empty = !full_q;
  assign txd        = line_q;

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> line_q);
  assert_hold_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_empty) |-> $past(wr));
  assert_start_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(tx_en));
endmodule

// File: rtl/aser_rx.sv
module aser_rx
  import aser_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_en,
  input  logic          nine,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          wake_addr,
  input  logic          sleep_req,
  input  logic          rd,
  input  logic          rxd,
  output logic [DW-1:0] data,
  output logic          full,
  output logic          noise,
  output logic          ferr,
  output logic          perr,
  output logic          ovr,
  output logic          asleep
);
  localparam int BW  = DW + 2;
  localparam int CW  = $clog2(BW + 1);
  localparam int IW  = $clog2(SAMPLES * (DW + 2) + 1);
  localparam int SBW = $clog2(SAMPLES);

  rx_state_e      st_q, st_d;
  logic           s1_q, s2_q;
  logic [SBW-1:0] smp_q, smp_d;
  logic [CW-1:0]  bit_q, bit_d, nd, nb;
  logic           s7_q, s7_d, s8_q, s8_d, noisy_q, noisy_d;
  logic [BW-1:0]  buf_q, buf_d;
  logic [IW-1:0]  idle_q, idle_d, lim;
  logic           sl_q, sl_d;
  logic [DW-1:0]  data_q, data_d, data_w;
  logic           full_q, full_d, noise_q, noise_d, ferr_q, ferr_d;
  logic           perr_q, perr_d, ovr_q, ovr_d;
  logic           line, vote, dis, done, deliver, msb, pe_w;

  assign line = s2_q;

  always_comb begin
    st_d = st_q; smp_d = smp_q; bit_d = bit_q; s7_d = s7_q; s8_d = s8_q;
    noisy_d = noisy_q; buf_d = buf_q; idle_d = idle_q; sl_d = sl_q;
    data_d = data_q; full_d = full_q; noise_d = noise_q; ferr_d = ferr_q;
    perr_d = perr_q; ovr_d = ovr_q;
    done   = 1'b0;
    nd     = nine ? CW'(DW) : CW'(DW - 1);
    nb     = nd + CW'(par_en) + CW'(1);
    lim    = nine ? IW'(SAMPLES * (DW + 2)) : IW'(SAMPLES * (DW + 1));
    vote   = (s7_q & s8_q) | (s7_q & line) | (s8_q & line);
    dis    = !((s7_q == s8_q) && (s8_q == line));
    data_w = nine ? buf_q[DW-1:0] : {1'b0, buf_q[DW-2:0]};
    msb    = nine ? buf_q[DW-1] : buf_q[DW-2];
    pe_w   = par_en && (((^data_w) ^ buf_q[nd]) != par_odd);
    if (!rx_en) st_d = RX_IDLE;
    else if (tick) begin
      case (st_q)
        RX_IDLE: if (!line) begin
          st_d = RX_START; smp_d = SBW'(2); noisy_d = 1'b0;
        end
        RX_START: begin
          smp_d = smp_q + SBW'(1);
          if (line && (smp_q == SBW'(3) || smp_q == SBW'(5) || smp_q == SBW'(7)))
            st_d = RX_IDLE;
          else if (smp_q == '0) begin
            st_d = RX_BITS; smp_d = SBW'(1); bit_d = '0;
          end
        end
        RX_BITS: begin
          smp_d = smp_q + SBW'(1);
          if (smp_q == SBW'(7)) s7_d = line;
          if (smp_q == SBW'(8)) s8_d = line;
          if (smp_q == SBW'(9)) begin
            noisy_d = noisy_q | dis;
            buf_d[bit_q] = vote;
            if (bit_q == nb - CW'(1)) begin
              done = 1'b1; st_d = RX_IDLE;
            end else bit_d = bit_q + CW'(1);
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
    deliver = done && (!sl_q || (wake_addr && msb));
    if (rd) begin
      full_d = 1'b0; noise_d = 1'b0; ferr_d = 1'b0; perr_d = 1'b0; ovr_d = 1'b0;
    end
    if (deliver) begin
      sl_d = 1'b0;
      if (full_q && !rd) ovr_d = 1'b1;
      else begin
        data_d = data_w; full_d = 1'b1; noise_d = noisy_q | dis;
        ferr_d = !vote; perr_d = pe_w;
      end
    end
    if (sleep_req) begin
      sl_d = 1'b1; idle_d = '0;
    end else if (sl_q && !wake_addr && rx_en && tick) begin
      if (st_q == RX_IDLE && line) begin
        idle_d = idle_q + IW'(1);
        if (idle_q + IW'(1) == lim) sl_d = 1'b0;
      end else idle_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= 1'b1; s2_q <= 1'b1; st_q <= RX_IDLE; smp_q <= '0; bit_q <= '0;
      s7_q <= 1'b1; s8_q <= 1'b1; noisy_q <= 1'b0; buf_q <= '0; idle_q <= '0;
      sl_q <= 1'b0; data_q <= '0; full_q <= 1'b0; noise_q <= 1'b0;
      ferr_q <= 1'b0; perr_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      s1_q <= rxd; s2_q <= s1_q; st_q <= st_d; smp_q <= smp_d; bit_q <= bit_d;
      s7_q <= s7_d; s8_q <= s8_d; noisy_q <= noisy_d; buf_q <= buf_d;
      idle_q <= idle_d; sl_q <= sl_d; data_q <= data_d; full_q <= full_d;
      noise_q <= noise_d; ferr_q <= ferr_d; perr_q <= perr_d; ovr_q <= ovr_d;
    end

  assign data = data_q;   assign full = full_q;   assign noise = noise_q;
  assign ferr = ferr_q;   assign perr = perr_q;   assign ovr = ovr_q;
  assign asleep = sl_q;

  assert_start_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_START && rx_en && tick && line && smp_q == SBW'(3)) |=> st_q == RX_IDLE);
  assert_overrun_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(full_q));
  assert_no_delivery_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(!sl_q || wake_addr));
  assert_flags_clear_on_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_q) |-> $past(rd));
endmodule

// File: rtl/aser_top.sv
module aser_top (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [12:0] baud_div,
  input  logic        nine_bit,
  input  logic        par_en,
  input  logic        par_odd,
  input  logic        tx_en,
  input  logic        rx_en,
  input  logic        wake_addr,
  input  logic        sleep_req,
  input  logic        tx_wr,
  input  logic [8:0]  tx_data,
  output logic        tx_hold_empty,
  output logic        txd,
  input  logic        rxd,
  input  logic        rx_rd,
  output logic [8:0]  rx_data,
  output logic        rx_full,
  output logic        rx_noise,
  output logic        rx_frame_err,
  output logic        rx_par_err,
  output logic        rx_overrun,
  output logic        rx_asleep
);
  localparam int DW = 9;
  logic tick;

  aser_baud #(.DIVW(13)) u_baud (.clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick));

  aser_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .nine(nine_bit),
    .par_en(par_en), .par_odd(par_odd), .wr(tx_wr), .wdata(tx_data),
    .hold_empty(tx_hold_empty), .txd(txd));

  aser_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en), .nine(nine_bit),
    .par_en(par_en), .par_odd(par_odd), .wake_addr(wake_addr),
    .sleep_req(sleep_req), .rd(rx_rd), .rxd(rxd), .data(rx_data),
    .full(rx_full), .noise(rx_noise), .ferr(rx_frame_err), .perr(rx_par_err),
    .ovr(rx_overrun), .asleep(rx_asleep));
endmodule

// File: tb/aser_top_bench.sv
module aser_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int BITC = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [12:0] baud_div = 13'(DIV);
  logic nine_bit = 0, par_en = 0, par_odd = 0, tx_en = 0, rx_en = 0;
  logic wake_addr = 0, sleep_req = 0, tx_wr = 0, rx_rd = 0, loop = 0, drv = 1;
  logic [8:0] tx_data = '0;
  logic tx_hold_empty, txd, rxd, rx_full, rx_noise, rx_frame_err, rx_par_err, rx_overrun, rx_asleep;
  logic [8:0] rx_data;
  int n_chk = 0, n_fail = 0, cyc = 0;

  assign rxd = loop ? txd : drv;
  always #(CLK_PERIOD/2) clk = ~clk;

  aser_top u_aser_top (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask

  task automatic do_sleep();
    @(negedge clk); sleep_req = 1; @(negedge clk); sleep_req = 0;
  endtask

  task automatic write_tx(input logic [8:0] v);
    @(negedge clk); tx_data = v; tx_wr = 1; @(negedge clk); tx_wr = 0;
  endtask

  task automatic wait_full(output bit got);
    got = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (rx_full) begin got = 1; break; end
    end
  endtask

  // one bench-driven frame; glitch_pos inverts one sample period in that frame bit
  task automatic send(input logic [8:0] v, input bit bad_par, input bit stop_low, input int glitch_pos);
    int n; logic b; logic [11:0] fr; int nb;
    n = nine_bit ? 9 : 8;
    fr = '1; fr[0] = 0;
    for (int i = 0; i < n; i++) fr[1+i] = v[i];
    if (par_en) fr[1+n] = (^(v & (nine_bit ? 9'h1FF : 9'h0FF))) ^ par_odd ^ bad_par;
    nb = n + 2 + int'(par_en);
    for (int k = 0; k < nb; k++) begin
      for (int c = 0; c < BITC; c++) begin
        @(negedge clk);
        b = fr[k];
        if (k == nb - 1 && stop_low && c < 80) b = 0;
        if (k == glitch_pos && c >= 58 && c < 66) b = ~b;
        drv = b;
      end
    end
    @(negedge clk); drv = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit got; logic [8:0] v, m; int lo;
    clks(3); rst_n = 1; clks(2);
    // R1 reset state
    check(txd == 1 && tx_hold_empty == 1, "R1 tx idle", {txd, tx_hold_empty}, 3);
    check({rx_full, rx_noise, rx_frame_err, rx_par_err, rx_overrun, rx_asleep} == 0,
          "R1 rx flags", {rx_full, rx_noise, rx_frame_err, rx_par_err, rx_overrun, rx_asleep}, 0);

    // R2 R3 loopback sweep over all formats
    tx_en = 1; rx_en = 1; loop = 1;
    for (int cfg = 0; cfg < 8; cfg++) begin
      nine_bit = cfg[0]; par_en = cfg[1]; par_odd = cfg[2];
      m = nine_bit ? 9'h1FF : 9'h0FF;
      for (int p = 0; p < 5; p++) begin
        case (p)
          0: v = 9'h000; 1: v = 9'h1FF; 2: v = 9'h155; 3: v = 9'h0AA;
          default: v = 9'(cfg * 37 + 129);
        endcase
        v = v & m;
        write_tx(v);
        wait_full(got);
        check(got && rx_data == v, "R2 loopback data", rx_data, v);
        check(!rx_par_err && !rx_frame_err && !rx_noise, "R3 loopback parity clean",
              {rx_par_err, rx_frame_err, rx_noise}, 0);
        pulse_rd();
        check(!rx_full, "R12 read clears full", rx_full, 0);
        clks(200);
      end
    end

    // R3 receiver parity sense with bench-computed parity
    loop = 0; nine_bit = 0; par_en = 1;
    for (int o = 0; o < 2; o++) begin
      par_odd = o[0];
      send(9'h0B3, 0, 0, -1);
      check(rx_full && !rx_par_err && rx_data == 9'h0B3, "R3 good parity", rx_par_err, 0);
      pulse_rd();
      send(9'h0B3, 1, 0, -1);
      check(rx_full && rx_par_err, "R3 bad parity flagged", rx_par_err, 1);
      pulse_rd();
      check(!rx_par_err, "R12 read clears parity flag", rx_par_err, 0);
    end
    par_en = 0;

    // R4 noise on a single sample of data bit 1 and of the stop bit
    send(9'h0A5, 0, 0, 2);
    check(rx_full && rx_noise && rx_data == 9'h0A5, "R4 noise flagged data kept", {rx_noise, rx_data}, {1'b1, 9'h0A5});
    pulse_rd();
    send(9'h03C, 0, 0, 9);
    check(rx_noise && !rx_frame_err && rx_data == 9'h03C, "R4 noise on stop", {rx_noise, rx_frame_err}, 2);
    pulse_rd();
    check(!rx_noise, "R12 read clears noise", rx_noise, 0);

    // R5 short low pulses are dropped
    for (int w = 1; w <= 2; w++) begin
      @(negedge clk); drv = 0; clks(w * DIV); drv = 1;
      clks(3 * BITC);
      check(!rx_full, "R5 short pulse dropped", rx_full, 0);
    end

    // R6 framing error
    send(9'h066, 0, 1, -1);
    clks(BITC);
    check(rx_full && rx_frame_err && rx_data == 9'h066, "R6 low stop", rx_frame_err, 1);
    pulse_rd();
    check(!rx_frame_err && !rx_full, "R6 no spurious frame", {rx_full, rx_frame_err}, 0);

    // R7 overrun
    send(9'h011, 0, 0, -1);
    send(9'h022, 0, 0, -1);
    check(rx_overrun && rx_data == 9'h011, "R7 overrun keeps first", {rx_overrun, rx_data}, {1'b1, 9'h011});
    pulse_rd();
    check(!rx_overrun && !rx_full, "R12 read clears overrun", {rx_overrun, rx_full}, 0);

    // R9 receiver disabled
    rx_en = 0;
    send(9'h044, 0, 0, -1);
    check(!rx_full, "R9 rx disabled", rx_full, 0);
    rx_en = 1;

    // R9 transmitter disabled
    loop = 1; tx_en = 0; lo = 0;
    write_tx(9'h055);
    for (int i = 0; i < 4 * BITC; i++) begin @(negedge clk); if (!txd) lo++; end
    check(lo == 0 && !tx_hold_empty, "R9 tx disabled holds line", lo, 0);
    tx_en = 1;
    wait_full(got);
    check(got && rx_data == 9'h055, "R9 tx resumes", rx_data, 9'h055);
    pulse_rd(); clks(200);

    // R8 double buffering
    write_tx(9'h0C1);
    clks(20);
    check(tx_hold_empty, "R8 hold drained to shifter", tx_hold_empty, 1);
    write_tx(9'h0C2);
    check(!tx_hold_empty, "R8 hold full", tx_hold_empty, 0);
    write_tx(9'h0C3);
    wait_full(got);
    check(got && rx_data == 9'h0C1, "R8 first word", rx_data, 9'h0C1);
    pulse_rd();
    wait_full(got);
    check(got && rx_data == 9'h0C2, "R8 second word", rx_data, 9'h0C2);
    pulse_rd();
    clks(2500);
    check(!rx_full && tx_hold_empty, "R8 write while full ignored", rx_full, 0);
    loop = 0;

    // R10 idle-line wake, 8-bit: 160 ticks
    wake_addr = 0; nine_bit = 0;
    do_sleep();
    check(rx_asleep, "R10 asleep", rx_asleep, 1);
    send(9'h077, 0, 0, -1);
    check(!rx_full && rx_asleep, "R10 frame suppressed", {rx_full, rx_asleep}, 1);
    clks(1100);
    check(rx_asleep, "R10 still asleep", rx_asleep, 1);
    clks(300);
    check(!rx_asleep, "R10 woke on idle", rx_asleep, 0);
    send(9'h078, 0, 0, -1);
    check(rx_full && rx_data == 9'h078, "R10 delivered after wake", rx_data, 9'h078);
    pulse_rd();
    do_sleep();
    clks(160 * DIV - 64);
    check(rx_asleep, "R10 8-bit before 160 ticks", rx_asleep, 1);
    clks(128);
    check(!rx_asleep, "R10 8-bit after 160 ticks", rx_asleep, 0);
    nine_bit = 1;
    do_sleep();
    clks(176 * DIV - 64);
    check(rx_asleep, "R10 9-bit before 176 ticks", rx_asleep, 1);
    clks(128);
    check(!rx_asleep, "R10 9-bit after 176 ticks", rx_asleep, 0);

    // R11 address-mark wake, 8-bit and 9-bit
    wake_addr = 1;
    for (int nb = 0; nb < 2; nb++) begin
      nine_bit = nb[0];
      do_sleep();
      send(9'h012, 0, 0, -1);
      clks(2000);
      check(!rx_full && rx_asleep, "R11 plain frame dropped", {rx_full, rx_asleep}, 1);
      v = nine_bit ? 9'h113 : 9'h093;
      send(v, 0, 0, -1);
      check(rx_full && !rx_asleep && rx_data == v, "R11 address frame wakes", rx_data, v);
      pulse_rd();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule